// File: doc/BRIEF.md
# Byte-Oriented I2C Bus Master with Register Interface

This block is an I2C bus master that software drives through five word-addressed byte registers. Software raises a master-select control bit to put a START on the bus, lowers it to put a STOP there, and combines it with a one-shot repeated-start bit to turn the bus around without releasing it. Bytes move one at a time. In transmit mode, a write to the data register sends the byte, and the address byte is sent this way too (device address in bits 7:1, direction in bit 0). In receive mode, a read of the data register hands back the byte last received and starts the next one. The first read after entering receive mode therefore only launches a transfer.

Software polls a status register to see completion, the interrupt flag, bus busy, arbitration loss and the acknowledge bit it received. A level interrupt output follows the flag when the interrupt enable bit is set. The bus pins are open-drain: each line has an active-high output enable that pulls it low, and an input that reads the resolved line level. The SCL rate comes from the low bits of a divider register. SDA only changes while SCL is steady, at least one system clock after the last SCL edge.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset the own-address, divider, control and data registers read 0x00, status reads 0x80 (only transfer complete), both output enables are 0 and `irq` is 0.
- R2: Registers are word offsets 0 own address, 1 divider, 2 control, 3 status, 4 data. Own address and divider read back all 8 written bits. Control bits are enable 7, interrupt enable 6, master select 5, transmit mode 4, no-acknowledge 3 and repeated start 2, and bit 2 always reads 0.
- R3: A control write that takes master select from 0 to 1 with enable (bit 7) set in the same write puts a START on the bus: SDA falls while SCL is high, and status bit 5 (bus busy) becomes 1. With enable clear, that write leaves master select at 0 and the bus untouched.
- R4: With `d` the low DIV_W (default 6) bits of the divider, and d=0 treated as 1, SCL is high for d+1 and low for d+1 system clocks in every bit, so the period is 2*(d+1). The upper divider bits have no effect on timing.
- R5: In transmit mode with master select set, a data-register write sends the 8 bits MSB first and then releases SDA for the acknowledge slot. Status bit 0 reads 1 if the receiver left SDA high there and 0 if it pulled SDA low.
- R6: While a byte is on the bus, status bit 7 (transfer complete) reads 0. At the end of the byte, bit 7 and bit 1 (interrupt flag) become 1. `irq` equals interrupt enable AND the flag. Writing 0 to a status bit clears the flag (bit 1) and arbitration-lost (bit 4).
- R7: In receive mode (master select 1, transmit mode 0), a data-register read returns the previously received byte and starts the next one. In that byte's acknowledge slot the master pulls SDA low when control bit 3 was 0 at launch and leaves SDA high when it was 1.
- R8: A control write with master select and repeated start both set, while master select is already 1, releases SDA, raises SCL and then pulls SDA low with SCL high. No STOP appears and bus busy stays 1.
- R9: A control write that takes master select from 1 to 0 puts a STOP on the bus: SDA rises while SCL is high, and bus busy returns to 0.
- R10: If SDA reads low at the end of an SCL-high phase in which the master sent a 1, status bits 4 and 1 are set, master select reads 0, and both output enables go to 0 without a STOP.
- R11: `scl_oe` and `sda_oe` never change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word offset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Resolved SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
Register reads are combinational, so each read is sampled in the same cycle as its strobe. A command takes effect from the clock edge that accepts the strobe, and one more edge is needed before the engine picks it up. The first bus phase of a command lasts d+1 clocks after that. SDA follows SCL by exactly one clock, which is why the bench samples both lines on the falling clock edge and sees the two changes on separate samples. Completion, flag and acknowledge results appear together at the end of the ninth SCL-high phase. The bench therefore polls status until the flag is set instead of counting to a fixed cycle, and it checks SCL period and bus conditions against a model slave that watches the lines every clock.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;

    localparam logic [2:0] ADR_OWN  = 3'd0;
    localparam logic [2:0] ADR_DIV  = 3'd1;
    localparam logic [2:0] ADR_CTRL = 3'd2;
    localparam logic [2:0] ADR_STAT = 3'd3;
    localparam logic [2:0] ADR_DATA = 3'd4;

    localparam int CB_EN   = 7;
    localparam int CB_IEN  = 6;
    localparam int CB_MSEL = 5;
    localparam int CB_TXM  = 4;
    localparam int CB_NACK = 3;
    localparam int CB_RPT  = 2;

    localparam int SB_DONE = 7;
    localparam int SB_BUSY = 5;
    localparam int SB_ARB  = 4;
    localparam int SB_FLAG = 1;

    typedef enum logic [2:0] {
        OP_START, OP_RSTART, OP_STOP, OP_TX, OP_RX
    } eng_op_e;

    typedef struct packed {
        eng_op_e    op;
        logic [7:0] data;
        logic       nack;
    } eng_cmd_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_HOLD, ST_BLO, ST_BHI, ST_ALO, ST_AHI,
        ST_RSA, ST_RSB, ST_SPA, ST_SPB, ST_SPC
    } eng_state_e;

    function automatic logic [7:0] eff_half(input logic [7:0] d);
        return (d == 8'd0) ? 8'd1 : d;
    endfunction

endpackage

// File: rtl/i2c_host_tick.sv
module i2c_host_tick
    import i2c_host_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = (div == '0) ? CW'(1) : CW'(div);
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt <= '0;
        else                    cnt <= cnt + CW'(1);
    end

    // every half period lasts at least two clocks
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/i2c_host_engine.sv
module i2c_host_engine
    import i2c_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cmd_valid,
    input  eng_cmd_t   cmd,
    input  logic       sda_in,
    output logic       cmd_take,
    output logic       done,
    output logic       done_rx,
    output logic       arb_lost,
    output logic       ack_bit,
    output logic [7:0] rx_byte,
    output logic       scl_low,
    output logic       sda_low
);
    eng_state_e state;
    logic [7:0] shreg;
    logic [2:0] bitcnt;
    logic       is_tx;
    logic       nack_q;
    logic       hold_low;
    logic       sda_want;

    assign cmd_take = cmd_valid && (state == ST_IDLE || state == ST_HOLD);
    assign rx_byte  = shreg;

    always_comb begin
        scl_low  = 1'b0;
        sda_want = 1'b0;
        unique case (state)
            ST_IDLE:  begin scl_low = 1'b0; sda_want = 1'b0; end
            ST_START: begin scl_low = 1'b0; sda_want = 1'b1; end
            ST_HOLD:  begin scl_low = 1'b1; sda_want = hold_low; end
            ST_BLO:   begin scl_low = 1'b1; sda_want = is_tx & ~shreg[7]; end
            ST_BHI:   begin scl_low = 1'b0; sda_want = is_tx & ~shreg[7]; end
            ST_ALO:   begin scl_low = 1'b1; sda_want = ~is_tx & ~nack_q; end
            ST_AHI:   begin scl_low = 1'b0; sda_want = ~is_tx & ~nack_q; end
            ST_RSA:   begin scl_low = 1'b1; sda_want = 1'b0; end
            ST_RSB:   begin scl_low = 1'b0; sda_want = 1'b0; end
            ST_SPA:   begin scl_low = 1'b1; sda_want = 1'b1; end
            ST_SPB:   begin scl_low = 1'b0; sda_want = 1'b1; end
            ST_SPC:   begin scl_low = 1'b0; sda_want = 1'b0; end
            default:  begin scl_low = 1'b0; sda_want = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            is_tx    <= 1'b0;
            nack_q   <= 1'b0;
            hold_low <= 1'b0;
            sda_low  <= 1'b0;
            done     <= 1'b0;
            done_rx  <= 1'b0;
            arb_lost <= 1'b0;
            ack_bit  <= 1'b0;
        end else begin
            done     <= 1'b0;
            arb_lost <= 1'b0;
            sda_low  <= sda_want;
            if (cmd_take) begin
                unique case (cmd.op)
                    OP_START:  if (state == ST_IDLE) state <= ST_START;
                    OP_RSTART: if (state == ST_HOLD) state <= ST_RSA;
                    OP_STOP:   if (state == ST_HOLD) state <= ST_SPA;
                    OP_TX, OP_RX: if (state == ST_HOLD) begin
                        state  <= ST_BLO;
                        bitcnt <= '0;
                        is_tx  <= (cmd.op == OP_TX);
                        nack_q <= cmd.nack;
                        shreg  <= (cmd.op == OP_TX) ? cmd.data : 8'h00;
                    end
                    default: ;
                endcase
            end else if (tick) begin
                unique case (state)
                    ST_START: begin state <= ST_HOLD; hold_low <= sda_want; end
                    ST_BLO:   state <= ST_BHI;
                    ST_BHI: begin
                        if (is_tx && shreg[7] && !sda_in) begin
                            arb_lost <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            shreg  <= is_tx ? {shreg[6:0], 1'b0} : {shreg[6:0], sda_in};
                            bitcnt <= bitcnt + 3'd1;
                            state  <= (bitcnt == 3'd7) ? ST_ALO : ST_BLO;
                        end
                    end
                    ST_ALO:   state <= ST_AHI;
                    ST_AHI: begin
                        if (is_tx) ack_bit <= sda_in;
                        done     <= 1'b1;
                        done_rx  <= ~is_tx;
                        hold_low <= sda_want;
                        state    <= ST_HOLD;
                    end
                    ST_RSA:   state <= ST_RSB;
                    ST_RSB:   state <= ST_START;
                    ST_SPA:   state <= ST_SPB;
                    ST_SPB:   state <= ST_SPC;
                    ST_SPC:   state <= ST_IDLE;
                    default: ;
                endcase
            end
        end
    end

    // SDA moves one clock after SCL, never together
    assert_edges_apart_R11: assert property (@(posedge clk) disable iff (rst)
        (scl_low != $past(scl_low)) |-> (sda_low == $past(sda_low)));

    // after a byte the clock is parked low
    assert_park_low_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> scl_low);

    // a lost bus is let go at once
    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        arb_lost |-> !scl_low);

endmodule

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
    import i2c_host_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       scl_oe,
    input  logic       scl_in,
    output logic       sda_oe,
    input  logic       sda_in
);
    logic [7:0] own_q, div_q, data_q;
    logic       en, ien, msel, txm, nack;
    logic       mcf, mif, mal, rxak, busy;
    logic       scl_q, sda_q;
    logic       pend_v;
    eng_cmd_t   pend;
    logic       issue;
    eng_cmd_t   issue_cmd;
    logic       tick, cmd_take, eng_done, eng_done_rx, eng_arb, eng_ack;
    logic [7:0] eng_rx;
    logic       scl_low, sda_low;
    logic       wr_ctrl, wr_data, rd_data;

    assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_data = bus_wr && (bus_addr == ADR_DATA);
    assign rd_data = bus_rd && (bus_addr == ADR_DATA);

    i2c_host_tick #(.DIV_W(DIV_W)) tick_i (
        .clk (clk),
        .rst (rst),
        .clr (cmd_take),
        .div (div_q[DIV_W-1:0]),
        .tick(tick)
    );

    i2c_host_engine eng_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cmd_valid(pend_v),
        .cmd      (pend),
        .sda_in   (sda_in),
        .cmd_take (cmd_take),
        .done     (eng_done),
        .done_rx  (eng_done_rx),
        .arb_lost (eng_arb),
        .ack_bit  (eng_ack),
        .rx_byte  (eng_rx),
        .scl_low  (scl_low),
        .sda_low  (sda_low)
    );

    assign scl_oe = scl_low;
    assign sda_oe = sda_low;
    assign irq    = ien & mif;

    // command decode from register traffic
    always_comb begin
        issue     = 1'b0;
        issue_cmd = '{op: OP_STOP, data: bus_wdata, nack: nack};
        if (wr_ctrl) begin
            if (!msel && bus_wdata[CB_MSEL] && bus_wdata[CB_EN]) begin
                issue = 1'b1; issue_cmd.op = OP_START;
            end else if (msel && !bus_wdata[CB_MSEL]) begin
                issue = 1'b1; issue_cmd.op = OP_STOP;
            end else if (msel && bus_wdata[CB_MSEL] && bus_wdata[CB_RPT]) begin
                issue = 1'b1; issue_cmd.op = OP_RSTART;
            end
        end else if (wr_data && msel && txm) begin
            issue = 1'b1; issue_cmd.op = OP_TX;
        end else if (rd_data && msel && !txm) begin
            issue = 1'b1; issue_cmd.op = OP_RX;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= '0; div_q <= '0; data_q <= '0;
            en <= 1'b0; ien <= 1'b0; msel <= 1'b0; txm <= 1'b0; nack <= 1'b0;
            mcf <= 1'b1; mif <= 1'b0; mal <= 1'b0; rxak <= 1'b0;
            pend_v <= 1'b0;
            pend   <= '{op: OP_STOP, data: 8'h00, nack: 1'b0};
        end else begin
            if (issue) begin
                pend_v <= 1'b1;
                pend   <= issue_cmd;
            end else if (cmd_take) begin
                pend_v <= 1'b0;
            end
            if (issue && (issue_cmd.op == OP_TX || issue_cmd.op == OP_RX)) mcf <= 1'b0;
            if (bus_wr) begin
                unique case (bus_addr)
                    ADR_OWN:  own_q <= bus_wdata;
                    ADR_DIV:  div_q <= bus_wdata;
                    ADR_CTRL: begin
                        en   <= bus_wdata[CB_EN];
                        ien  <= bus_wdata[CB_IEN];
                        txm  <= bus_wdata[CB_TXM];
                        nack <= bus_wdata[CB_NACK];
                        msel <= bus_wdata[CB_MSEL] && (msel || bus_wdata[CB_EN]);
                    end
                    ADR_STAT: begin
                        mif <= mif & bus_wdata[SB_FLAG];
                        mal <= mal & bus_wdata[SB_ARB];
                    end
                    ADR_DATA: data_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (eng_done) begin
                mcf <= 1'b1;
                mif <= 1'b1;
                if (eng_done_rx) data_q <= eng_rx;
                else             rxak   <= eng_ack;
            end
            if (eng_arb) begin
                mcf    <= 1'b1;
                mif    <= 1'b1;
                mal    <= 1'b1;
                msel   <= 1'b0;
                pend_v <= 1'b0;
            end
        end
    end

    // bus condition monitor
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1; sda_q <= 1'b1; busy <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (scl_in && scl_q && sda_q && !sda_in)      busy <= 1'b1;
            else if (scl_in && scl_q && !sda_q && sda_in) busy <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_OWN:  bus_rdata = own_q;
            ADR_DIV:  bus_rdata = div_q;
            ADR_CTRL: bus_rdata = {en, ien, msel, txm, nack, 3'b000};
            ADR_STAT: bus_rdata = {mcf, 1'b0, busy, mal, 2'b00, mif, rxak};
            ADR_DATA: bus_rdata = data_q;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assert_flag_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> (mcf && mif));

    assert_arb_drops_master_R10: assert property (@(posedge clk) disable iff (rst)
        eng_arb |=> (!msel && mal));

    assert_no_start_without_enable_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !msel && !bus_wdata[CB_EN]) |=> !msel);

endmodule

// File: tb/i2c_host_ctrl_tb.sv
module i2c_host_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       slv_low = 1'b0, other_low = 1'b0;
    wire        scl_line = ~scl_oe;
    wire        sda_line = ~(sda_oe | slv_low | other_low);

    int checks = 0, errors = 0, cyc = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    i2c_host_ctrl #(.DIV_W(6)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'hC3 ^ 8'(i * 8'h35);
    endfunction

    // model slave at address 0x50, line watcher
    localparam logic [6:0] SLV = 7'h50;
    logic sclp = 1'b1, sdap = 1'b1, sclo_p = 1'b0, sdao_p = 1'b0;
    int   bitn = 0, starts = 0, stops = 0, wcnt = 0, tidx = 0, skew = 0;
    int   rise1 = 0, per_meas = 0;
    logic in_addr = 0, s_act = 0, s_rd = 0, s_tx = 0, m_ack = 0;
    logic [7:0] rsh = 0;
    logic [7:0] wlog [0:31];
    logic       ack_log [0:15];

    always @(negedge clk) begin
        cyc++;
        if (scl_oe != sclo_p && sda_oe != sdao_p) skew++;
        sclo_p = scl_oe; sdao_p = sda_oe;
        if (sclp && scl_line && sdap && !sda_line) begin
            starts++; bitn = 0; in_addr = 1; s_tx = 0; s_act = 0; slv_low = 0; tidx = 0;
        end else if (sclp && scl_line && !sdap && sda_line) begin
            stops++; in_addr = 0; s_tx = 0; s_act = 0; slv_low = 0;
        end else if (scl_line && !sclp) begin
            if (bitn < 8) rsh = {rsh[6:0], sda_line};
            else if (s_tx) begin m_ack = !sda_line; ack_log[tidx] = m_ack; tidx++; end
            if (bitn == 1) rise1 = cyc;
            if (bitn == 2) per_meas = cyc - rise1;
            bitn++;
        end else if (!scl_line && sclp) begin
            if (bitn == 8) begin
                if (in_addr) begin s_act = (rsh[7:1] == SLV); s_rd = rsh[0]; slv_low = s_act; end
                else if (s_act && !s_tx) begin wlog[wcnt] = rsh; wcnt++; slv_low = 1; end
                else slv_low = 0;
            end else if (bitn == 9) begin
                bitn = 0; slv_low = 0;
                if (in_addr) begin
                    in_addr = 0; s_tx = s_act && s_rd;
                    if (s_tx) slv_low = !pat(tidx)[7];
                end else if (s_tx) begin
                    if (m_ack) slv_low = !pat(tidx)[7];
                    else s_tx = 0;
                end
            end else if (s_tx && bitn < 8) begin
                slv_low = !pat(tidx)[7-bitn];
            end
        end
        sclp = scl_line; sdap = sda_line;
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_flag(input string req);
        logic [7:0] s;
        for (int n = 0; n < 3000; n++) begin
            rd(3'd3, s);
            if (s[1]) return;
        end
        chk(req, 32'(0), 32'(1));
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int st0, sp0, w0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset view
        rd(3'd0, v); chk("R1 own", v, 8'h00);
        rd(3'd1, v); chk("R1 div", v, 8'h00);
        rd(3'd2, v); chk("R1 ctrl", v, 8'h00);
        rd(3'd3, v); chk("R1 status", v, 8'h80);
        rd(3'd4, v); chk("R1 data", v, 8'h00);
        chk("R1 pins", {scl_oe, sda_oe, irq}, 3'b000);
        // R2 register map
        wr(3'd0, 8'h5A); rd(3'd0, v); chk("R2 own", v, 8'h5A);
        wr(3'd1, 8'h87); rd(3'd1, v); chk("R2 div", v, 8'h87);
        wr(3'd2, 8'h5C); rd(3'd2, v); chk("R2 ctrl rpt reads 0", v, 8'h58);
        // R3 master select without enable does nothing
        wr(3'd2, 8'h7C); repeat (60) @(negedge clk);
        chk("R3 no start count", starts, 0);
        rd(3'd2, v); chk("R3 msel stays 0", v[5], 1'b0);
        rd(3'd3, v); chk("R3 not busy", v[5], 1'b0);
        wr(3'd2, 8'h00);
        // divider sweep, write transfers
        foreach (sweep_divs[k]) begin
            int d, per;
            logic [7:0] b;
            d = sweep_divs[k];
            per = 2 * (((d & 63) == 0) ? 1 : (d & 63)) + 2;
            b = 8'h96 ^ 8'(k * 8'h2B);
            wr(3'd1, 8'(d));
            st0 = starts; sp0 = stops; w0 = wcnt;
            wr(3'd2, 8'h80); wr(3'd2, 8'hB0);
            repeat (30) @(negedge clk);
            chk("R3 start seen", starts, st0 + 1);
            rd(3'd3, v); chk("R3 busy set", v[5], 1'b1);
            wr(3'd4, {SLV, 1'b0});
            repeat (2) @(negedge clk);
            rd(3'd3, v); chk("R6 done low in flight", v[7], 1'b0);
            wait_flag("R6 flag");
            rd(3'd3, v); chk("R5 addr acked status", v, 8'hA2);
            chk("R4 scl period", per_meas, per);
            chk("R6 irq off without enable", irq, 1'b0);
            wr(3'd3, 8'h00); rd(3'd3, v); chk("R6 flag cleared", v[1], 1'b0);
            wr(3'd4, b); wait_flag("R5 data");
            chk("R5 byte msb first", wlog[w0], b);
            wr(3'd3, 8'h00);
            wr(3'd2, 8'h80); repeat (40) @(negedge clk);
            chk("R9 stop seen", stops, sp0 + 1);
            rd(3'd3, v); chk("R9 busy clear", v[5], 1'b0);
        end
        wr(3'd1, 8'h03);
        // R5 no acknowledge, R6 interrupt line
        wr(3'd2, 8'hF0); repeat (20) @(negedge clk);
        wr(3'd4, {7'h22, 1'b0}); wait_flag("R5 nack");
        rd(3'd3, v); chk("R5 nack status", v, 8'hA3);
        chk("R6 irq high", irq, 1'b1);
        wr(3'd3, 8'h00); @(negedge clk);
        chk("R6 irq low after clear", irq, 1'b0);
        wr(3'd2, 8'h80); repeat (30) @(negedge clk);
        // R8 repeated start, R7 receive
        wr(3'd2, 8'hB0); repeat (20) @(negedge clk);
        wr(3'd4, {SLV, 1'b0}); wait_flag("R8 addr"); wr(3'd3, 8'h00);
        st0 = starts; sp0 = stops;
        wr(3'd2, 8'hB4); repeat (30) @(negedge clk);
        chk("R8 extra start", starts, st0 + 1);
        chk("R8 no stop", stops, sp0);
        rd(3'd3, v); chk("R8 still busy", v[5], 1'b1);
        wr(3'd4, {SLV, 1'b1}); wait_flag("R8 read addr"); wr(3'd3, 8'h00);
        wr(3'd2, 8'hA0);
        rd(3'd4, v);
        wait_flag("R7 b0"); wr(3'd3, 8'h00);
        rd(3'd4, v); chk("R7 byte0", v, pat(0));
        wait_flag("R7 b1"); wr(3'd3, 8'h00);
        wr(3'd2, 8'hA8);
        rd(3'd4, v); chk("R7 byte1", v, pat(1));
        wait_flag("R7 b2"); wr(3'd3, 8'h00);
        wr(3'd2, 8'h80); repeat (30) @(negedge clk);
        rd(3'd4, v); chk("R7 byte2", v, pat(2));
        chk("R7 acks", {ack_log[0], ack_log[1], ack_log[2]}, 3'b110);
        chk("R9 stop after read", stops, sp0 + 1);
        // R10 arbitration loss
        wr(3'd2, 8'hB0); repeat (20) @(negedge clk);
        other_low = 1'b1;
        wr(3'd4, 8'h80); wait_flag("R10 flag");
        rd(3'd3, v); chk("R10 lost+flag", v & 8'h12, 8'h12);
        rd(3'd2, v); chk("R10 msel cleared", v, 8'h90);
        repeat (4) @(negedge clk);
        chk("R10 lines released", {scl_oe, sda_oe}, 2'b00);
        other_low = 1'b0; repeat (4) @(negedge clk);
        wr(3'd3, 8'h00); rd(3'd3, v); chk("R10 lost cleared", v & 8'h12, 8'h00);
        chk("R11 no same-edge changes", skew, 0);
        finish_run();
    end

    int sweep_divs [5] = '{1, 4, 0, 8'h43, 2};

endmodule